// File: doc/BRIEF.md
# Dual-Mode Serial Port

This block is one serial channel that can work in two ways. In asynchronous mode it sends and receives full-duplex character frames with start and stop bits. In clocked synchronous mode it exchanges one byte with a peer, either as the master that drives the bit clock or as a slave that follows a clock from outside. Transmit and receive each use one shift register in both modes. A received character is placed in a one-entry buffer. The receiver sets sticky error flags. An interrupt request is the OR of all pending events.

Software uses a small register bus with three addresses: control, status and data. The bit rate comes from `baud_tick`, which is a one-cycle pulse from an external timer. In asynchronous mode this pulse runs at 16 times the bit rate. In master mode, each pulse is one half-period of the serial clock. The block tells the pin multiplexer which of its four pins it currently owns. The pins it does not own stay with general-purpose I/O.

Top module: `dual_serial_port`

## Requirements
- R1: After reset the following hold:
  - control (address 0) reads 0 and status (address 1) reads 0;
  - `pin_own` is 0;
  - `sout` is 1, `sclk_out` is 1, `srdy` is 0 and `irq` is 0.
- R2: Control bit 0 enables the pins. Control bits 2:1 select the mode: 00 and 11 are asynchronous, 01 is synchronous master and 10 is synchronous slave. `pin_own` bit 0 is data in, bit 1 is data out, bit 2 is clock and bit 3 is ready.
  - With the enable set, asynchronous mode owns bits 1:0, master owns bits 2:0 and slave owns all four bits.
  - `sclk_oe` is 1 only for an enabled master.
  - With the enable clear, `pin_own` is 0.
- R3: A write to address 2 starts an asynchronous frame on `sout`. Each bit lasts 16 ticks. The frame is sent LSB first and has these fields in order:
  - a low start bit;
  - 7 data bits, or 8 data bits when control bit 3 is 1;
  - a parity bit when control bit 4 is 1 (even parity, or odd parity when control bit 5 is 1);
  - a high stop bit.
  When the frame ends, status bit 1 (busy) clears and status bit 5 (transmit done) sets.
- R4: After a falling edge on `sin`, the receiver samples each bit at its 8th tick. A complete frame loads the data into the buffer (bit 7 reads 0 in 7-bit mode) and sets status bit 0 (buffer full).
- R5: A start bit that is high again at its sampling point is dropped. No flag is set.
- R6: In master mode a write to address 2 sends 8 bits LSB first. `sclk_out` idles high and toggles on every tick, falling first. `sin` is sampled on each rising edge and `sout` advances after it. The received byte then fills the buffer.
- R7: In slave mode a write to address 2 arms a transfer, and `srdy` stays high until 8 rising edges of `sclk_in` have passed. Clock edges seen while not armed have no effect.
- R8: A received parity bit that does not match the check sets status bit 2.
- R9: A low stop bit sets status bit 3.
- R10: A frame that completes while the buffer is full sets status bit 4 and leaves the buffer unchanged.
- R11: Writing 1 to status bits 2 to 5 clears them. Reading address 2 clears buffer full.
- R12: `irq` is high exactly while any of status bits 0, 2, 3, 4 or 5 is set.
- R13: A transmit write is ignored while busy or while the pin enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| baud_tick | input | 1 | Bit-rate pulse from the external timer |
| irq | output | 1 | Interrupt request |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out |
| sclk_in | input | 1 | Serial clock from the master (slave mode) |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Output enable for the clock pin |
| srdy | output | 1 | Slave ready |
| pin_own | output | 4 | Pin ownership: data in, data out, clock, ready |

## Verification
Asynchronous frames are tried as 8 data bits with no parity, 7 data bits with even parity and 8 data bits with odd parity. These three separate the data-length and parity options from one another. On the receive side the bench sends:
- a clean frame;
- a frame with parity inverted;
- a frame with a low stop bit;
- two frames back to back with no read between them;
- a short low pulse.

These show that each error flag is set only by its own cause, and that noise is rejected. Master and slave exchanges use different bytes in each direction, so that swapped lanes or bit order would show up. An unarmed clock pulse in slave mode shows that edges are ignored until the slave is armed.

// File: rtl/serport_pkg.sv
`timescale 1ns/1ps
package serport_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC  = 2'd0,
    MODE_MASTER = 2'd1,
    MODE_SLAVE  = 2'd2,
    MODE_ALT    = 2'd3
  } mode_e;

  // parity over the active data bits; odd selects odd parity
  function automatic logic par_bit(input logic [7:0] d, input logic len8, input logic odd);
    return (^(d & (len8 ? 8'hFF : 8'h7F))) ^ odd;
  endfunction

  // total bits in an asynchronous frame, start and stop included
  function automatic logic [3:0] frame_len(input logic len8, input logic pen);
    return 4'd9 + {3'd0, len8} + {3'd0, pen};
  endfunction

  // transmit image, bit 0 leaves first, unused upper bits are stop level
  function automatic logic [10:0] build_frame(input logic [7:0] d, input logic len8,
                                              input logic pen, input logic odd);
    logic [10:0] f;
    f = '1;
    if (len8) begin
      f[8:1] = d;
      if (pen) f[9] = par_bit(d, len8, odd);
    end else begin
      f[7:1] = d[6:0];
      if (pen) f[8] = par_bit(d, len8, odd);
    end
    f[0] = 1'b0;
    return f;
  endfunction
endpackage

// File: rtl/serport_txpath.sv
`timescale 1ns/1ps
module serport_txpath import serport_pkg::*; #(
  parameter int OVS_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       is_sync,
  input  logic       is_master,
  input  logic       len8,
  input  logic       pen,
  input  logic       podd,
  input  logic       ext_rise,
  output logic       sout,
  output logic       sclk_out,
  output logic       busy,
  output logic       done,
  output logic       shift_rise
);
  logic [10:0]      sh;
  logic [3:0]       bitn;
  logic [OVS_W-1:0] sub;
  logic [3:0]       last_bit;
  logic             async_step, master_rise, step;

  assign last_bit    = is_sync ? 4'd7 : frame_len(len8, pen) - 4'd1;
  assign async_step  = !is_sync && baud_tick && (sub == '1);
  assign master_rise = baud_tick && !sclk_out;
  assign shift_rise  = busy && is_sync && (is_master ? master_rise : ext_rise);
  assign step        = busy && (async_step || shift_rise);
  assign sout        = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '1;
      bitn     <= '0;
      sub      <= '0;
      busy     <= 1'b0;
      sclk_out <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load && !busy) begin
        sh       <= is_sync ? {3'b111, din} : build_frame(din, len8, pen, podd);
        bitn     <= '0;
        sub      <= '0;
        busy     <= 1'b1;
        sclk_out <= 1'b1;
      end else if (busy) begin
        if (baud_tick && !is_sync) sub <= sub + 1'b1;
        if (baud_tick && is_master) sclk_out <= ~sclk_out;
        if (step) begin
          sh   <= {1'b1, sh[10:1]};
          bitn <= bitn + 4'd1;
          if (bitn == last_bit) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_out);
  assert_done_ends_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/serport_rxpath.sv
`timescale 1ns/1ps
module serport_rxpath import serport_pkg::*; #(
  parameter int OVS_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       sin_s,
  input  logic       is_sync,
  input  logic       len8,
  input  logic       pen,
  input  logic       podd,
  input  logic       sync_rise,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       par_bad,
  output logic       stop_bad
);
  localparam logic [OVS_W-1:0] MID = OVS_W'((1 << OVS_W) / 2 - 1);

  logic             active, sin_d, par_rx, start_edge;
  logic [OVS_W-1:0] sub;
  logic [3:0]       idx, last_idx, dbits;
  logic [7:0]       acc;

  assign last_idx   = frame_len(len8, pen) - 4'd1;
  assign dbits      = len8 ? 4'd8 : 4'd7;
  assign start_edge = !is_sync && !active && sin_d && !sin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      sin_d    <= 1'b1;
      sub      <= '0;
      idx      <= '0;
      acc      <= '0;
      par_rx   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      par_bad  <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      sin_d    <= sin_s;
      rx_valid <= 1'b0;
      if (is_sync) begin
        active <= 1'b0;
        if (sync_rise) begin
          acc <= {sin_s, acc[7:1]};
          if (idx == 4'd7) begin
            idx      <= '0;
            rx_valid <= 1'b1;
            rx_data  <= {sin_s, acc[7:1]};
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
          end else begin
            idx <= idx + 4'd1;
          end
        end
      end else if (!active) begin
        if (start_edge) begin
          active <= 1'b1;
          sub    <= '0;
          idx    <= '0;
        end
      end else if (baud_tick) begin
        sub <= sub + 1'b1;
        if (sub == MID) begin
          if (idx == 4'd0) begin
            if (sin_s) active <= 1'b0;
            else       idx    <= 4'd1;
          end else if (idx == last_idx) begin
            active   <= 1'b0;
            idx      <= '0;
            rx_valid <= 1'b1;
            rx_data  <= len8 ? acc : {1'b0, acc[6:0]};
            par_bad  <= pen && (par_rx != par_bit(acc, len8, podd));
            stop_bad <= !sin_s;
          end else if (idx <= dbits) begin
            acc[idx[2:0] - 3'd1] <= sin_s;
            idx <= idx + 4'd1;
          end else begin
            par_rx <= sin_s;
            idx    <= idx + 4'd1;
          end
        end
      end
    end
  end

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/dual_serial_port.sv
`timescale 1ns/1ps
module dual_serial_port import serport_pkg::*; #(
  parameter int OVS_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       baud_tick,
  output logic       irq,
  input  logic       sin,
  output logic       sout,
  input  logic       sclk_in,
  output logic       sclk_out,
  output logic       sclk_oe,
  output logic       srdy,
  output logic [3:0] pin_own
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  logic [5:0] ctrl;
  logic       pin_en, len8, pen, podd, is_sync, is_master, is_slave;
  logic [1:0] mode;
  logic [1:0] sync1, sync2;
  logic       sin_s, sclk_s, sclk_d, ext_rise;
  logic       tx_busy, tx_done_p, shift_rise, load;
  logic       rx_valid, par_bad, stop_bad;
  logic [7:0] rx_data, rx_buf;
  logic       rx_full, par_err, frm_err, ovr_err, tx_done;
  logic       data_rd, stat_wr;

  assign pin_en    = ctrl[0];
  assign mode      = ctrl[2:1];
  assign len8      = ctrl[3];
  assign pen       = ctrl[4];
  assign podd      = ctrl[5];
  assign is_master = (mode == MODE_MASTER);
  assign is_slave  = (mode == MODE_SLAVE);
  assign is_sync   = is_master || is_slave;

  // two-stage input synchronisers, bit 0 data, bit 1 clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= 2'b11;
      sync2  <= 2'b11;
      sclk_d <= 1'b1;
    end else begin
      sync1  <= {sclk_in, sin};
      sync2  <= sync1;
      sclk_d <= sync2[1];
    end
  end
  assign sin_s    = sync2[0];
  assign sclk_s   = sync2[1];
  assign ext_rise = is_slave && sclk_s && !sclk_d;

  assign load    = bus_wr && (bus_addr == A_DATA) && pin_en;
  assign data_rd = bus_rd && (bus_addr == A_DATA);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);

  serport_txpath #(.OVS_W(OVS_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(load), .din(bus_wdata),
    .is_sync(is_sync), .is_master(is_master), .len8(len8), .pen(pen), .podd(podd),
    .ext_rise(ext_rise), .sout(sout), .sclk_out(sclk_out), .busy(tx_busy),
    .done(tx_done_p), .shift_rise(shift_rise));

  serport_rxpath #(.OVS_W(OVS_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .sin_s(sin_s), .is_sync(is_sync),
    .len8(len8), .pen(pen), .podd(podd), .sync_rise(shift_rise), .rx_valid(rx_valid),
    .rx_data(rx_data), .par_bad(par_bad), .stop_bad(stop_bad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      rx_buf  <= '0;
      rx_full <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      ovr_err <= 1'b0;
      tx_done <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl <= bus_wdata[5:0];
      if (data_rd) rx_full <= 1'b0;
      if (stat_wr) begin
        if (bus_wdata[2]) par_err <= 1'b0;
        if (bus_wdata[3]) frm_err <= 1'b0;
        if (bus_wdata[4]) ovr_err <= 1'b0;
        if (bus_wdata[5]) tx_done <= 1'b0;
      end
      if (rx_valid) begin
        if (rx_full && !data_rd) begin
          ovr_err <= 1'b1;
        end else begin
          rx_buf  <= rx_data;
          rx_full <= 1'b1;
        end
        if (par_bad)  par_err <= 1'b1;
        if (stop_bad) frm_err <= 1'b1;
      end
      if (tx_done_p) tx_done <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {2'b00, ctrl};
      A_STAT:  bus_rdata = {2'b00, tx_done, ovr_err, frm_err, par_err, tx_busy, rx_full};
      A_DATA:  bus_rdata = rx_buf;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign pin_own = pin_en ? {is_slave, is_sync, 1'b1, 1'b1} : 4'b0000;
  assign sclk_oe = pin_own[2] && is_master;
  assign srdy    = pin_own[3] && tx_busy;
  assign irq     = rx_full || par_err || frm_err || ovr_err || tx_done;

  assert_full_from_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_valid));
  assert_ovr_needs_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(rx_full));
  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_full && !tx_done && !par_err && !frm_err && !ovr_err) |-> !irq);
endmodule

// File: tb/test_dual_serial_port.sv
`timescale 1ns/1ps
module test_dual_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       baud_tick = 1'b0;
  logic       irq, sout, sclk_out, sclk_oe, srdy;
  logic       sin = 1'b1, sclk_in = 1'b1;
  logic [3:0] pin_own;

  int vectors = 0;
  int misses = 0;
  int tcnt = 0;
  logic [5:0] m_ctrl = 6'd0;
  logic fq[$];
  logic [7:0] rv;

  always #2 clk = ~clk;

  dual_serial_port i_dual_serial_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .baud_tick(baud_tick), .irq(irq),
    .sin(sin), .sout(sout), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .srdy(srdy), .pin_own(pin_own));

  // tick every 4 clocks
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    baud_tick = (tcnt == 0);
  end

  task automatic expect_eq(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // behavioural model of pin roles: {sclk_oe, pin_own}
  function automatic logic [4:0] role_model(input logic [5:0] c);
    int m;
    m = c[2:1];
    if (!c[0]) return 5'b00000;
    if (m == 1) return 5'b10111;
    if (m == 2) return 5'b01111;
    return 5'b00011;
  endfunction

  always @(posedge clk) begin
    #1;
    if (rst_n) expect_eq("R2 pin roles per cycle", {sclk_oe, pin_own}, role_model(m_ctrl));
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (a == 2'd0) m_ctrl = d[5:0];
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    expect_eq(tag, v, exp);
  endtask

  // frame image: start, data LSB first, parity, stop
  task automatic make_frame(input logic [7:0] d, input bit len8, input bit pen, input bit odd,
                            input bit badpar, input logic stopv);
    int ones, nb;
    nb = len8 ? 8 : 7;
    ones = 0;
    fq.delete();
    fq.push_back(1'b0);
    for (int i = 0; i < nb; i++) begin
      fq.push_back(d[i]);
      if (d[i]) ones++;
    end
    if (pen) fq.push_back(logic'((ones % 2) ^ int'(odd) ^ int'(badpar)));
    fq.push_back(stopv);
  endtask

  task automatic check_tx(input string tag, input int first_wait);
    repeat (first_wait) @(negedge clk);
    foreach (fq[i]) begin
      expect_eq(tag, sout, fq[i]);
      repeat (64) @(negedge clk);
    end
  endtask

  task automatic send_rx();
    foreach (fq[i]) begin
      sin = fq[i];
      repeat (64) @(negedge clk);
    end
    sin = 1'b1;
    repeat (64) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_eq("R1 sout idle", sout, 1'b1);
    expect_eq("R1 sclk idle", sclk_out, 1'b1);
    expect_eq("R1 srdy low", srdy, 1'b0);
    expect_eq("R1 pins free", pin_own, 4'h0);
    expect_eq("R1 irq low", irq, 1'b0);
    expect_reg("R1 ctrl", 2'd0, 8'h00);
    expect_reg("R1 status", 2'd1, 8'h00);

    // R13 transmit with pins disabled
    wr(2'd2, 8'h55);
    repeat (100) @(negedge clk);
    expect_eq("R13 disabled sout", sout, 1'b1);
    expect_reg("R13 disabled status", 2'd1, 8'h00);

    // R3 8 data bits, no parity
    wr(2'd0, 8'h09);
    wr(2'd2, 8'hA5);
    make_frame(8'hA5, 1, 0, 0, 0, 1'b1);
    check_tx("R3 frame 8N", 30);
    expect_reg("R3 done flag", 2'd1, 8'h20);
    expect_eq("R12 irq on tx done", irq, 1'b1);
    wr(2'd1, 8'h20);
    expect_reg("R11 w1c tx done", 2'd1, 8'h00);
    expect_eq("R12 irq cleared", irq, 1'b0);

    // R3 7 bits even parity, R13 write while busy ignored
    wr(2'd0, 8'h11);
    wr(2'd2, 8'hDB);
    wr(2'd2, 8'h00);
    make_frame(8'hDB, 0, 1, 0, 0, 1'b1);
    check_tx("R3 R13 frame 7E", 28);
    expect_reg("R3 done 7E", 2'd1, 8'h20);
    repeat (64) @(negedge clk);
    expect_eq("R13 no second frame", sout, 1'b1);
    wr(2'd1, 8'h20);

    // R3 8 bits odd parity
    wr(2'd0, 8'h39);
    wr(2'd2, 8'h3C);
    make_frame(8'h3C, 1, 1, 1, 0, 1'b1);
    check_tx("R3 frame 8O", 30);
    wr(2'd1, 8'h20);

    // R4 receive 8N
    wr(2'd0, 8'h09);
    make_frame(8'h3C, 1, 0, 0, 0, 1'b1);
    send_rx();
    expect_reg("R4 rx full", 2'd1, 8'h01);
    expect_eq("R12 irq on rx", irq, 1'b1);
    expect_reg("R4 rx data", 2'd2, 8'h3C);
    expect_reg("R11 read clears full", 2'd1, 8'h00);

    // R4 7E good, R8 bad parity
    wr(2'd0, 8'h11);
    make_frame(8'hC5, 0, 1, 0, 0, 1'b1);
    send_rx();
    expect_reg("R4 rx 7E status", 2'd1, 8'h01);
    expect_reg("R4 rx 7E data", 2'd2, 8'h45);
    make_frame(8'h2A, 0, 1, 0, 1, 1'b1);
    send_rx();
    expect_reg("R8 parity flag", 2'd1, 8'h05);
    rd(2'd2, rv);
    wr(2'd1, 8'h04);
    expect_reg("R11 parity cleared", 2'd1, 8'h00);

    // R9 framing error
    wr(2'd0, 8'h09);
    make_frame(8'h81, 1, 0, 0, 0, 1'b0);
    send_rx();
    expect_reg("R9 framing flag", 2'd1, 8'h09);
    expect_reg("R9 data kept", 2'd2, 8'h81);
    wr(2'd1, 8'h08);
    expect_reg("R11 framing cleared", 2'd1, 8'h00);

    // R5 noise pulse
    sin = 1'b0;
    repeat (8) @(negedge clk);
    sin = 1'b1;
    repeat (200) @(negedge clk);
    expect_reg("R5 glitch ignored", 2'd1, 8'h00);
    expect_eq("R5 no irq", irq, 1'b0);

    // R10 overrun
    make_frame(8'h11, 1, 0, 0, 0, 1'b1);
    send_rx();
    make_frame(8'h22, 1, 0, 0, 0, 1'b1);
    send_rx();
    expect_reg("R10 overrun flag", 2'd1, 8'h11);
    expect_reg("R10 first byte kept", 2'd2, 8'h11);
    wr(2'd1, 8'h10);
    expect_reg("R11 overrun cleared", 2'd1, 8'h00);

    // R6 master exchange: send 96, receive 4D
    wr(2'd0, 8'h03);
    expect_eq("R6 sclk idle", sclk_out, 1'b1);
    wr(2'd2, 8'h96);
    for (int i = 0; i < 8; i++) begin
      while (sclk_out !== 1'b0) @(negedge clk);
      expect_eq("R6 master sout bit", sout, 8'h96 >> i & 1);
      sin = (8'h4D >> i) & 1;
      while (sclk_out !== 1'b1) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    sin = 1'b1;
    expect_reg("R6 master status", 2'd1, 8'h21);
    expect_reg("R6 master rx", 2'd2, 8'h4D);
    wr(2'd1, 8'h20);

    // R7 slave: unarmed pulse ignored, then exchange 3A / C1
    wr(2'd0, 8'h05);
    expect_eq("R7 srdy idle", srdy, 1'b0);
    sclk_in = 1'b0; repeat (8) @(negedge clk);
    sclk_in = 1'b1; repeat (8) @(negedge clk);
    expect_reg("R7 unarmed edge ignored", 2'd1, 8'h00);
    wr(2'd2, 8'h3A);
    expect_eq("R7 srdy armed", srdy, 1'b1);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0;
      sin = (8'hC1 >> i) & 1;
      repeat (8) @(negedge clk);
      expect_eq("R7 slave sout bit", sout, 8'h3A >> i & 1);
      sclk_in = 1'b1;
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    expect_eq("R7 srdy released", srdy, 1'b0);
    expect_reg("R7 slave status", 2'd1, 8'h21);
    expect_reg("R7 slave rx", 2'd2, 8'hC1);

    // R2 pins returned
    wr(2'd0, 8'h00);
    repeat (4) @(negedge clk);
    expect_eq("R2 pins released", pin_own, 4'h0);
    finish_run();
  end
endmodule